// File: doc/BRIEF.md
# Lockable Instruction Cache Controller

This block is the front end of a small direct-mapped instruction cache with 32-byte lines. A fetch port presents a word address, a request and a caching-inhibited attribute, and gets back one 32-bit instruction word. Misses go out on a system bus read port. That port carries either single-beat reads or four-beat bursts of 64 bits. Three software control bits decide what happens to each fetch:
- **enable** turns the cache on.
- **lock** freezes the cache contents.
- **flash invalidate** clears all lines at once.

Two further ports can drop one line. A snoop port names a line address. A block-invalidate port does the same as a software operation.

A single state machine sequences every access.
- **S_IDLE** accepts a fetch and looks up the tag array in that same cycle. A hit stays in S_IDLE and answers on the next cycle.
- A bypass access (cache disabled, or inhibited attribute set) goes **S_IDLE → S_SINGLE**. It returns to S_IDLE when its one beat arrives.
- A cacheable miss goes **S_IDLE → S_BURST**. It returns to S_IDLE on the fourth beat.

During S_BURST:
- The requested word is forwarded one cycle after the beat that carries it.
- The line is written into the data store beat by beat.
- The line is marked valid only at the last beat, and only if the fill was allowed to allocate and nothing invalidated that line while the fill was running.

Top module: `icf_top`

## Requirements
- R1: After reset the enable, lock and flash-invalidate bits all read 0, `fetch_ready` is 0 and `bus_req` is 0.
- R2: While enable is 0, every fetch is issued as a single-beat read. This holds even for a line that was valid before the cache was disabled. The read has `bus_burst`=0 and `bus_addr` equal to the fetch byte address with bits [2:0] cleared.
- R3: During every bus request, `bus_ci` equals the inhibit attribute of the access that caused it, for every setting of enable and lock. It stays steady for the whole request.
- R4: When enabled, a non-inhibited miss issues a burst with `bus_burst`=1 and `bus_addr` aligned to 32 bytes. Beat k carries bytes 8k..8k+7 of the line, with the lower-addressed word in bits [31:0]. `fetch_ready` rises one cycle after the beat holding the requested word, which may be before the burst ends, and it is a one-cycle pulse.
- R5: When enabled and unlocked, a completed burst makes its line valid. A later fetch to any word of that line is answered one cycle after acceptance, with no bus request and with the data stored at fill time.
- R6: An access with the inhibit attribute set is always a single-beat read and never allocates a line. A following non-inhibited fetch to the same line therefore misses.
- R7: While locked, a fetch that hits is served from the cache without a bus request.
- R8: While locked, a miss issues a burst and returns the correct word, but does not allocate. A second fetch to the same line goes to the bus again.
- R9: While locked, the block-invalidate port has no effect on the tags. A snoop that matches a line still invalidates it.
- R10: Writing flash-invalidate as 1 clears all valid bits. The bit reads 1 on the cycle after the write. It reads 0 one cycle later if enable is 1, and stays 1 while enable is 0.
- R11: Writing flash-invalidate as 1 and then as 0 on two consecutive control writes leaves the cache exactly as a single write of 1 does: all lines invalid.
- R12: The block-invalidate port clears a matching line even while the cache is disabled.
- R13: If a snoop or a block invalidate matches the line of a burst fill in progress, that fill does not mark the line valid when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the three control bits |
| ctl_en | input | 1 | Enable value to write |
| ctl_lock | input | 1 | Lock value to write |
| ctl_flash | input | 1 | Flash-invalidate value to write |
| en_o | output | 1 | Current enable bit |
| lock_o | output | 1 | Current lock bit |
| flash_o | output | 1 | Current flash-invalidate bit |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_waddr | input | ADDR_W-2 | Fetch word address (byte address bits [ADDR_W-1:2]) |
| fetch_ci | input | 1 | Caching-inhibited attribute of the fetch |
| fetch_ready | output | 1 | One-cycle pulse: `fetch_word` is valid |
| fetch_word | output | 32 | Returned instruction word |
| bus_req | output | 1 | Bus read request, held until the last beat |
| bus_burst | output | 1 | 1 for a four-beat burst, 0 for a single beat |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_ci | output | 1 | Caching-inhibited attribute on the bus |
| bus_valid | input | 1 | Read beat valid |
| bus_data | input | 64 | Read beat data |
| snp_req | input | 1 | Snoop invalidate strobe |
| snp_line | input | ADDR_W-5 | Snoop line address |
| inv_req | input | 1 | Block-invalidate strobe |
| inv_line | input | ADDR_W-5 | Block-invalidate line address |

## Verification
The bench changes the memory contents between fills. This separates a word served from the cache from one refetched, and each case also counts how many bus requests it caused.
- **Lock mode:** the bench proves that a locked miss is not remembered and that a locked hit is served. A design that allocated under lock would answer the second fetch without the bus. A design that ignored lock would let the block invalidate drop the line.
- **Flash invalidate:** the bench covers the single write, the write of 1 then 0, and the case with the cache disabled. A design that cleared the bit before using it, or never cleared it, would show a live line or a stuck bit.
- **Fill in flight:** a snoop or block invalidate is fired into the middle of a running burst. A design that drops the kill marks a stale line valid, and the next fetch then causes no bus request.

// File: rtl/icf_pkg.sv
package icf_pkg;
    localparam int OFF_W   = 5;                 // byte offset bits in a 32-byte line
    localparam int WOFF_W  = OFF_W - 2;         // word offset bits in a line
    localparam int BEATS   = 4;                 // beats per line fill
    localparam int BEAT_IW = $clog2(BEATS);     // beat index width
    localparam int WORD_W  = 32;                // instruction word width
    localparam int BEAT_W  = 2 * WORD_W;        // bus beat width

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SINGLE = 2'd1,
        S_BURST  = 2'd2
    } icf_state_e;
endpackage

// File: rtl/icf_ctl_regs.sv
module icf_ctl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_en,
    input  logic ctl_lock,
    input  logic ctl_flash,
    output logic en_q,
    output logic lock_q,
    output logic flash_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            lock_q  <= 1'b0;
            flash_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q    <= ctl_en;
            lock_q  <= ctl_lock;
            flash_q <= ctl_flash;
        end else if (flash_q && en_q) begin
            // the set bit has done its work this cycle; drop it
            flash_q <= 1'b0;
        end
    end
endmodule

// File: rtl/icf_tag_array.sv
module icf_tag_array #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             flash,
    input  logic             snp_en,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [TAG_W-1:0] alloc_tag
);
    logic [NUM_LINES-1:0] hit_vec;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             drop;

        assign drop = (snp_en && snp_idx == IDX_W'(i) && t_q == snp_tag) ||
                      (inv_en && inv_idx == IDX_W'(i) && t_q == inv_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (flash) begin
                v_q <= 1'b0;
            end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
                v_q <= 1'b1;
                t_q <= alloc_tag;
            end else if (drop) begin
                v_q <= 1'b0;
            end
        end

        assign hit_vec[i] = v_q && (t_q == lk_tag) && (lk_idx == IDX_W'(i));
    end

    assign lk_hit = |hit_vec;
endmodule

// File: rtl/icf_data_store.sv
module icf_data_store
    import icf_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BEAT_IW-1:0] wr_beat,
    input  logic [BEAT_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [BEAT_IW-1:0] rd_beat,
    output logic [BEAT_W-1:0]  rd_data
);
    localparam int DEPTH = NUM_LINES * BEATS;

    logic [BEAT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_beat}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_beat}];
endmodule

// File: rtl/icf_fsm.sv
module icf_fsm
    import icf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    input  logic [ADDR_W-3:0]  fetch_waddr,
    input  logic               fetch_ci,
    output logic               fetch_ready,
    output logic [WORD_W-1:0]  fetch_word,
    input  logic               en,
    input  logic               lock,
    input  logic               flash,
    input  logic               lk_hit,
    input  logic [BEAT_W-1:0]  rd_data,
    output logic               bus_req,
    output logic               bus_burst,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_ci,
    input  logic               bus_valid,
    input  logic [BEAT_W-1:0]  bus_data,
    input  logic               snp_req,
    input  logic [ADDR_W-OFF_W-1:0] snp_line,
    input  logic               blk_inv,
    input  logic [ADDR_W-OFF_W-1:0] inv_line,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [BEAT_IW-1:0] wr_beat,
    output logic [BEAT_W-1:0]  wr_data,
    output logic               alloc_en,
    output logic [IDX_W-1:0]   alloc_idx,
    output logic [TAG_W-1:0]   alloc_tag
);
    localparam int WA_W   = ADDR_W - 2;
    localparam int LINE_W = ADDR_W - OFF_W;

    icf_state_e state_q, state_d;

    logic [WA_W-1:0]    addr_q;
    logic               ci_q, alloc_q, kill_q, rdy_q;
    logic [BEAT_IW-1:0] beat_q;
    logic [WORD_W-1:0]  word_q;

    logic              accept, hit_now, kill_now, last_beat;
    logic [LINE_W-1:0] fill_line;

    function automatic logic [WORD_W-1:0] pick(input logic [BEAT_W-1:0] d, input logic hi);
        return hi ? d[BEAT_W-1:WORD_W] : d[WORD_W-1:0];
    endfunction

    assign accept    = (state_q == S_IDLE) && fetch_req && !rdy_q;
    assign hit_now   = en && !fetch_ci && lk_hit;
    assign fill_line = addr_q[WA_W-1 -: LINE_W];
    assign kill_now  = flash || (snp_req && snp_line == fill_line) ||
                       (blk_inv && inv_line == fill_line);
    assign last_beat = bus_valid && (beat_q == BEAT_IW'(BEATS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept && !hit_now) begin
                    state_d = (!en || fetch_ci) ? S_SINGLE : S_BURST;
                end
            end
            S_SINGLE: if (bus_valid) state_d = S_IDLE;
            S_BURST:  if (last_beat) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_burst = 1'b0;
        bus_ci    = 1'b0;
        bus_addr  = {addr_q[WA_W-1:1], 3'b000};
        wr_en     = 1'b0;
        alloc_en  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                bus_req = 1'b0;
            end
            S_SINGLE: begin
                bus_req = 1'b1;
                bus_ci  = ci_q;
            end
            S_BURST: begin
                bus_req   = 1'b1;
                bus_burst = 1'b1;
                bus_ci    = ci_q;
                bus_addr  = {fill_line, {OFF_W{1'b0}}};
                wr_en     = bus_valid && alloc_q;
                alloc_en  = last_beat && alloc_q && !kill_q && !kill_now;
            end
            default: begin
                bus_req = 1'b0;
            end
        endcase
    end

    assign wr_idx      = addr_q[WOFF_W +: IDX_W];
    assign wr_beat     = beat_q;
    assign wr_data     = bus_data;
    assign alloc_idx   = addr_q[WOFF_W +: IDX_W];
    assign alloc_tag   = addr_q[WA_W-1 -: TAG_W];
    assign fetch_ready = rdy_q;
    assign fetch_word  = word_q;

    // access datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            ci_q    <= 1'b0;
            alloc_q <= 1'b0;
            kill_q  <= 1'b0;
            rdy_q   <= 1'b0;
            beat_q  <= '0;
            word_q  <= '0;
        end else begin
            rdy_q <= 1'b0;
            if (accept) begin
                addr_q  <= fetch_waddr;
                ci_q    <= fetch_ci;
                alloc_q <= en && !lock && !fetch_ci;
                beat_q  <= '0;
                kill_q  <= 1'b0;
                if (hit_now) begin
                    word_q <= pick(rd_data, fetch_waddr[0]);
                    rdy_q  <= 1'b1;
                end
            end
            if (state_q == S_SINGLE && bus_valid) begin
                word_q <= pick(bus_data, addr_q[0]);
                rdy_q  <= 1'b1;
            end
            if (state_q == S_BURST) begin
                if (kill_now) kill_q <= 1'b1;
                if (bus_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == addr_q[BEAT_IW:1]) begin
                        word_q <= pick(bus_data, addr_q[0]);
                        rdy_q  <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/icf_top.sv
module icf_top
    import icf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_LINES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic                    ctl_en,
    input  logic                    ctl_lock,
    input  logic                    ctl_flash,
    output logic                    en_o,
    output logic                    lock_o,
    output logic                    flash_o,
    input  logic                    fetch_req,
    input  logic [ADDR_W-3:0]       fetch_waddr,
    input  logic                    fetch_ci,
    output logic                    fetch_ready,
    output logic [WORD_W-1:0]       fetch_word,
    output logic                    bus_req,
    output logic                    bus_burst,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    bus_ci,
    input  logic                    bus_valid,
    input  logic [BEAT_W-1:0]       bus_data,
    input  logic                    snp_req,
    input  logic [ADDR_W-OFF_W-1:0] snp_line,
    input  logic                    inv_req,
    input  logic [ADDR_W-OFF_W-1:0] inv_line
);
    localparam int WA_W   = ADDR_W - 2;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = LINE_W - IDX_W;

    logic               lk_hit, blk_inv;
    logic [BEAT_W-1:0]  rd_data, wr_data;
    logic               wr_en, alloc_en;
    logic [IDX_W-1:0]   wr_idx, alloc_idx;
    logic [BEAT_IW-1:0] wr_beat;
    logic [TAG_W-1:0]   alloc_tag;

    // a locked cache lets only snoops change tag state
    assign blk_inv = inv_req && !lock_o;

    icf_ctl_regs u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_en   (ctl_en),
        .ctl_lock (ctl_lock),
        .ctl_flash(ctl_flash),
        .en_q     (en_o),
        .lock_q   (lock_o),
        .flash_q  (flash_o)
    );

    icf_tag_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (fetch_waddr[WOFF_W +: IDX_W]),
        .lk_tag   (fetch_waddr[WA_W-1 -: TAG_W]),
        .lk_hit   (lk_hit),
        .flash    (flash_o),
        .snp_en   (snp_req),
        .snp_idx  (snp_line[IDX_W-1:0]),
        .snp_tag  (snp_line[LINE_W-1 -: TAG_W]),
        .inv_en   (blk_inv),
        .inv_idx  (inv_line[IDX_W-1:0]),
        .inv_tag  (inv_line[LINE_W-1 -: TAG_W]),
        .alloc_en (alloc_en),
        .alloc_idx(alloc_idx),
        .alloc_tag(alloc_tag)
    );

    icf_data_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_data (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_beat(wr_beat),
        .wr_data(wr_data),
        .rd_idx (fetch_waddr[WOFF_W +: IDX_W]),
        .rd_beat(fetch_waddr[BEAT_IW:1]),
        .rd_data(rd_data)
    );

    icf_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .fetch_waddr(fetch_waddr),
        .fetch_ci   (fetch_ci),
        .fetch_ready(fetch_ready),
        .fetch_word (fetch_word),
        .en         (en_o),
        .lock       (lock_o),
        .flash      (flash_o),
        .lk_hit     (lk_hit),
        .rd_data    (rd_data),
        .bus_req    (bus_req),
        .bus_burst  (bus_burst),
        .bus_addr   (bus_addr),
        .bus_ci     (bus_ci),
        .bus_valid  (bus_valid),
        .bus_data   (bus_data),
        .snp_req    (snp_req),
        .snp_line   (snp_line),
        .blk_inv    (blk_inv),
        .inv_line   (inv_line),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_beat    (wr_beat),
        .wr_data    (wr_data),
        .alloc_en   (alloc_en),
        .alloc_idx  (alloc_idx),
        .alloc_tag  (alloc_tag)
    );
endmodule

// File: rtl/icf_checker.sv
module icf_checker (
    input logic clk,
    input logic rst_n,
    input logic fetch_ready,
    input logic bus_req,
    input logic bus_burst,
    input logic bus_ci,
    input logic bus_valid,
    input logic en_o,
    input logic flash_o,
    input logic ctl_wr
);
    // R3: the inhibit attribute on the bus does not change within a request
    a_r3_ci_steady: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && $past(bus_req) |-> $stable(bus_ci));

    // R6: an inhibited request is never a burst
    a_r6_inhibit_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ci |-> !bus_burst);

    // R4: the word-ready strobe is a single-cycle pulse
    a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |=> !fetch_ready);

    // R4: a burst cannot end without a beat arriving
    a_r4_burst_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst && !bus_valid |=> bus_burst);

    // R10: with the cache enabled a set flash bit lasts one cycle
    a_r10_flash_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flash_o && en_o && !ctl_wr |=> !flash_o);
endmodule

bind icf_top icf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_ready(fetch_ready),
    .bus_req    (bus_req),
    .bus_burst  (bus_burst),
    .bus_ci     (bus_ci),
    .bus_valid  (bus_valid),
    .en_o       (en_o),
    .flash_o    (flash_o),
    .ctl_wr     (ctl_wr)
);

// File: tb/icf_top_tb.sv
`timescale 1ns/1ps
module icf_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_en = 1'b0, ctl_lock = 1'b0, ctl_flash = 1'b0;
    logic        en_o, lock_o, flash_o;
    logic        fetch_req = 1'b0;
    logic [29:0] fetch_waddr = '0;
    logic        fetch_ci = 1'b0;
    logic        fetch_ready;
    logic [31:0] fetch_word;
    logic        bus_req, bus_burst, bus_ci;
    logic [31:0] bus_addr;
    logic        bus_valid = 1'b0;
    logic [63:0] bus_data = '0;
    logic        snp_req = 1'b0, inv_req = 1'b0;
    logic [26:0] snp_line = '0, inv_line = '0;

    int total = 0;
    int bad = 0;
    logic [31:0] gen = 32'h1357_0000;

    int          rsp_cnt = 0;
    logic [31:0] rsp_addr = '0;
    logic        rsp_burst = 1'b0;
    logic        rsp_ci = 1'b0;

    always #2.5 clk = ~clk;

    icf_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_lock(ctl_lock), .ctl_flash(ctl_flash),
        .en_o(en_o), .lock_o(lock_o), .flash_o(flash_o),
        .fetch_req(fetch_req), .fetch_waddr(fetch_waddr), .fetch_ci(fetch_ci),
        .fetch_ready(fetch_ready), .fetch_word(fetch_word),
        .bus_req(bus_req), .bus_burst(bus_burst), .bus_addr(bus_addr), .bus_ci(bus_ci),
        .bus_valid(bus_valid), .bus_data(bus_data),
        .snp_req(snp_req), .snp_line(snp_line), .inv_req(inv_req), .inv_line(inv_line)
    );

    function automatic logic [31:0] mw(input logic [31:0] a, input logic [31:0] g);
        logic [31:0] b;
        b = {a[31:2], 2'b00};
        return (b * 32'h0001_0003) ^ g;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus memory model: one idle cycle, then the beats back to back
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                int n;
                logic [31:0] base;
                rsp_cnt++;
                rsp_addr  = bus_addr;
                rsp_burst = bus_burst;
                rsp_ci    = bus_ci;
                base = bus_addr;
                n = bus_burst ? 4 : 1;
                for (int k = 0; k < n; k++) begin
                    @(negedge clk);
                    bus_valid = 1'b1;
                    bus_data  = {mw(base + 32'(8*k) + 32'd4, gen), mw(base + 32'(8*k), gen)};
                end
                @(negedge clk);
                bus_valid = 1'b0;
            end
        end
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic ctl(input bit e, input bit l, input bit f);
        ctl_wr = 1'b1; ctl_en = e; ctl_lock = l; ctl_flash = f;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit ci,
                            output logic [31:0] w, output int lat, output int nreq, output bit early);
        int c0;
        c0 = rsp_cnt;
        fetch_waddr = a[31:2];
        fetch_ci = ci;
        fetch_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!fetch_ready && lat < 200);
        w = fetch_word;
        early = bus_req;
        fetch_req = 1'b0;
        repeat (8) @(negedge clk);
        nreq = rsp_cnt - c0;
    endtask

    task automatic t_reset;
        check(en_o == 0 && lock_o == 0 && flash_o == 0, "R1 ctl bits", {en_o, lock_o, flash_o}, 0);
        check(fetch_ready == 0 && bus_req == 0, "R1 idle outputs", {fetch_ready, bus_req}, 0);
    endtask

    task automatic t_fill;
        logic [31:0] w; int lat, nr; bit early; logic [31:0] g0;
        ctl(1, 0, 0);
        g0 = gen;
        do_fetch(32'h0000_0100, 0, w, lat, nr, early);
        check(nr == 1 && rsp_burst == 1, "R4 miss bursts", {nr, rsp_burst}, {32'd1, 1'b1});
        check(rsp_addr == 32'h100, "R4 burst line address", rsp_addr, 32'h100);
        check(w == mw(32'h100, g0), "R4 first word", w, mw(32'h100, g0));
        check(early == 1, "R4 forwarded before burst end", early, 1);
        gen = gen + 32'h0101_0000;
        do_fetch(32'h0000_011C, 0, w, lat, nr, early);
        check(nr == 0 && lat == 1, "R5 hit no bus", {nr, lat}, {32'd0, 32'd1});
        check(w == mw(32'h11C, g0), "R5 hit returns stored word", w, mw(32'h11C, g0));
        do_fetch(32'h0000_023C, 0, w, lat, nr, early);
        check(w == mw(32'h23C, gen) && early == 0, "R4 last-beat upper word", w, mw(32'h23C, gen));
    endtask

    task automatic t_bypass;
        logic [31:0] w; int lat, nr; bit early;
        do_fetch(32'h0000_06A4, 0, w, lat, nr, early);
        check(nr == 1 && rsp_burst == 1, "R5 fill F", nr, 1);
        ctl(0, 0, 0);
        do_fetch(32'h0000_06AC, 0, w, lat, nr, early);
        check(nr == 1 && rsp_burst == 0, "R2 disabled single beat", {nr, rsp_burst}, {32'd1, 1'b0});
        check(rsp_addr == 32'h6A8, "R2 single address", rsp_addr, 32'h6A8);
        check(w == mw(32'h6AC, gen), "R2 single word", w, mw(32'h6AC, gen));
        do_fetch(32'h0000_06A0, 1, w, lat, nr, early);
        check(rsp_ci == 1 && nr == 1, "R3 ci while disabled", rsp_ci, 1);
        ctl(1, 0, 0);
    endtask

    task automatic t_inhibit;
        logic [31:0] w; int lat, nr; bit early;
        do_fetch(32'h0000_07C8, 1, w, lat, nr, early);
        check(nr == 1 && rsp_burst == 0 && rsp_ci == 1, "R6 inhibited single", {nr, rsp_burst, rsp_ci}, {32'd1, 2'b01});
        check(w == mw(32'h7C8, gen), "R6 inhibited word", w, mw(32'h7C8, gen));
        do_fetch(32'h0000_07C8, 0, w, lat, nr, early);
        check(nr == 1 && rsp_burst == 1 && rsp_ci == 0, "R6 no allocation, R3 ci low", {nr, rsp_burst, rsp_ci}, {32'd1, 2'b10});
        do_fetch(32'h0000_07CC, 0, w, lat, nr, early);
        check(nr == 0, "R5 line G now hits", nr, 0);
    endtask

    task automatic t_lock;
        logic [31:0] w; int lat, nr; bit early; logic [31:0] g0;
        g0 = gen;
        do_fetch(32'h0000_0344, 0, w, lat, nr, early);
        gen = gen + 32'h0202_0000;
        ctl(1, 1, 0);
        do_fetch(32'h0000_0350, 0, w, lat, nr, early);
        check(nr == 0 && w == mw(32'h350, g0), "R7 locked hit", w, mw(32'h350, g0));
        do_fetch(32'h0000_0468, 0, w, lat, nr, early);
        check(nr == 1 && rsp_burst == 1 && w == mw(32'h468, gen), "R8 locked miss burst", w, mw(32'h468, gen));
        do_fetch(32'h0000_0468, 0, w, lat, nr, early);
        check(nr == 1, "R8 locked miss not allocated", nr, 1);
        do_fetch(32'h0000_0460, 1, w, lat, nr, early);
        check(rsp_ci == 1 && rsp_burst == 0, "R3 ci while locked", rsp_ci, 1);
        inv_line = 27'h340 >> 5; inv_req = 1'b1;
        @(negedge clk); inv_req = 1'b0;
        do_fetch(32'h0000_0340, 0, w, lat, nr, early);
        check(nr == 0, "R9 block invalidate ignored under lock", nr, 0);
        snp_line = 27'h340 >> 5; snp_req = 1'b1;
        @(negedge clk); snp_req = 1'b0;
        do_fetch(32'h0000_0340, 0, w, lat, nr, early);
        check(nr == 1, "R9 snoop invalidates under lock", nr, 1);
        ctl(1, 0, 0);
    endtask

    task automatic t_flash;
        logic [31:0] w; int lat, nr; bit early;
        do_fetch(32'h0000_0104, 0, w, lat, nr, early);
        check(nr == 0, "R5 A still valid", nr, 0);
        ctl(1, 0, 1);
        check(flash_o == 1, "R10 flash bit set", flash_o, 1);
        @(negedge clk);
        check(flash_o == 0, "R10 flash bit self clears", flash_o, 0);
        do_fetch(32'h0000_0104, 0, w, lat, nr, early);
        check(nr == 1, "R10 flash invalidated A", nr, 1);
        do_fetch(32'h0000_07C0, 0, w, lat, nr, early);
        check(nr == 1, "R10 flash invalidated G", nr, 1);
        ctl(1, 0, 1);
        ctl(1, 0, 0);
        check(flash_o == 0, "R11 bit low after 1,0", flash_o, 0);
        do_fetch(32'h0000_0104, 0, w, lat, nr, early);
        check(nr == 1, "R11 1-then-0 invalidated A", nr, 1);
        ctl(0, 0, 1);
        @(negedge clk);
        check(flash_o == 1, "R10 bit held while disabled", flash_o, 1);
        ctl(1, 0, 0);
    endtask

    task automatic t_inv_off;
        logic [31:0] w; int lat, nr; bit early;
        do_fetch(32'h0000_0220, 0, w, lat, nr, early);
        do_fetch(32'h0000_0224, 0, w, lat, nr, early);
        check(nr == 0, "R5 B valid", nr, 0);
        ctl(0, 0, 0);
        inv_line = 27'h220 >> 5; inv_req = 1'b1;
        @(negedge clk); inv_req = 1'b0;
        ctl(1, 0, 0);
        do_fetch(32'h0000_0224, 0, w, lat, nr, early);
        check(nr == 1 && rsp_burst == 1, "R12 invalidate while disabled", nr, 1);
    endtask

    task automatic t_kill(input logic [31:0] a, input bit use_snoop);
        logic [31:0] w; int lat, nr; bit early;
        fork
            do_fetch(a, 0, w, lat, nr, early);
            begin
                wait (bus_req);
                @(negedge clk);
                if (use_snoop) begin snp_line = a[31:5]; snp_req = 1'b1; end
                else           begin inv_line = a[31:5]; inv_req = 1'b1; end
                @(negedge clk);
                snp_req = 1'b0; inv_req = 1'b0;
            end
        join
        check(w == mw(a, gen), "R13 word during killed fill", w, mw(a, gen));
        do_fetch(a, 0, w, lat, nr, early);
        check(nr == 1, "R13 killed fill left line invalid", nr, 1);
        do_fetch(a, 0, w, lat, nr, early);
        check(nr == 0, "R13 clean refill valid", nr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_bypass();
        t_inhibit();
        t_lock();
        t_flash();
        t_inv_off();
        t_kill(32'h0000_0588, 1);
        t_kill(32'h0000_08E4, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule